// File: doc/BRIEF.md
# Three-Stage Cascadable Down-Counter with Toggle Pin

This block holds three 8-bit down-counters behind a small register bus. Each counter has its own reload latch. Each one steps down by one on a single-cycle count enable, and that enable is chosen by a bit in a shared control register. When a counter is at zero and receives a count enable, it takes the value in its latch and raises an underflow pulse for one cycle. Counters two and three can use the underflow of counter one as their count enable. This lets the three be chained into longer periods.

The count enables come from three places:
- a divide-by-sixteen prescaler that runs on every system clock, or only on sub-clock ticks when the low-speed input is high;
- the sub-clock tick input directly;
- the underflow of counter one.

An output pin inverts on every underflow of counter two. A control bit enables this behaviour. A second control bit sets the level the pin starts from. Another control bit lets software write counter two's latch without touching its running count.

Top module: `tri_timer_unit`

## Requirements
- R1: The control register sits at address 3. Its six low bits read back as written and reset to 0. Bits 7 and 6 always read 0, whatever was written.
- R2: Addresses 0, 1 and 2 select counters one, two and three. A read returns the live count, not the latch. After reset every count and every latch holds 8'hFF.
- R3: On each count enable a nonzero count drops by one. A zero count reloads from the latch and produces a one-cycle underflow, so a latch value N gives a period of N+1 enables.
- R4: A write to counter one or counter three loads both its latch and its count. A write to counter two does the same while control bit 2 is 0. A counter write in the same cycle as a count enable wins over the enable.
- R5: While control bit 2 is 1, a write to counter two changes only its latch. The count keeps running and takes the new value at its next underflow. This includes an underflow in the same cycle as the write.
- R6: Control bit 5 picks counter one's enable: 0 selects the prescaler pulse, 1 selects the sub-clock tick input.
- R7: Control bits 3 and 4 pick the enables of counters two and three: 0 selects counter one's underflow pulse, 1 selects the prescaler pulse. A counter one underflow caused by an enable at clock edge k steps the chained counter at edge k+1.
- R8: The prescaler gives exactly one pulse in every 16 consecutive system clocks while the low-speed input is 0. While it is 1, it gives exactly one pulse in every 16 sub-clock ticks and none without ticks.
- R9: While control bit 1 (toggle enable) is 0, the pin shows the start level from control bit 0: 0 means high, 1 means low. Counter two underflows leave it unchanged. After reset the pin is high.
- R10: A control write that sets bit 1 from 0 puts the pin at the start level that the same write selects. While enabled, the pin inverts on every counter two underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lowspd_i | input | 1 | Low-speed mode: prescaler advances only on sub-clock ticks |
| subtick_i | input | 1 | Single-cycle sub-clock tick enable |
| bus_addr | input | 2 | Register address (0..2 counters, 3 control) |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tgl_o | output | 1 | Toggle output pin |

## Verification
The collision case is a latch-only write to counter two in the same cycle that counter two underflows. The bench sets counter one and counter two to zero, with counter two chained to counter one. It then issues one sub-clock tick and places the write on the following cycle, which is when the chained enable reaches counter two. The case is judged by reading counter two afterwards. It must hold the freshly written value, not the old latch contents, and one more tick must then decrement it. A second case lets a counter write meet a prescaler pulse. There the bench relies on the write winning and measures the next decrement relative to the write.

// File: rtl/tt_pkg.sv
// Package: shared constants and types for the three-stage timer.
// Assumes an 8-bit data bus and a 2-bit register address.
package tt_pkg;

    localparam int unsigned N_TMR = 3;
    localparam int unsigned AW    = 2;
    localparam int unsigned DW    = 8;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd3;

    // Control register layout; the bit order is what software writes.
    typedef struct packed {
        logic t1_sub;      // bit 5: counter one enable from sub-clock tick
        logic t3_fast;     // bit 4: counter three enable from prescaler
        logic t2_fast;     // bit 3: counter two enable from prescaler
        logic t2_latonly;  // bit 2: counter two write goes to latch only
        logic tgl_en;      // bit 1: toggle output enabled
        logic tgl_low;     // bit 0: toggle output starts low
    } ctrl_t;

endpackage

// File: rtl/tt_prescale.sv
// Module: free-running prescaler.
// An internal counter advances on every cycle where adv_i is high. A single-cycle
// pulse is produced on the advance that wraps the counter, i.e. one pulse per
// 2**PW advances. Assumes adv_i is synchronous to clk.
module tt_prescale #(
    parameter int unsigned PW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic pulse_o
);
    localparam logic [PW-1:0] TOP = {PW{1'b1}};

    logic [PW-1:0] div_q;

    // Purpose: advance the divider on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (adv_i) begin
            div_q <= div_q + 1'b1;
        end
    end

    // Purpose: flag the wrapping advance.
    always_comb begin
        pulse_o = adv_i && (div_q == TOP);
    end

endmodule

// File: rtl/tt_counter.sv
// Module: one down-counter with a reload latch.
// On tick_i a nonzero count decrements, and a zero count reloads from the latch
// (including a latch value written in the same cycle), raising uf_o for one cycle
// after that edge. A counter load (ld_cnt_i) has priority over tick_i.
// Assumes ld_cnt_i implies ld_lat_i.
module tt_counter #(
    parameter int unsigned    W       = 8,
    parameter logic [W-1:0]   RST_VAL = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         ld_lat_i,
    input  logic         ld_cnt_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o
);
    logic [W-1:0] lat_q;
    logic [W-1:0] cnt_q;
    logic         uf_q;
    logic [W-1:0] lat_next;

    // Purpose: latch value seen this cycle, including a same-cycle write.
    always_comb begin
        lat_next = ld_lat_i ? wdata_i : lat_q;
    end

    // Purpose: hold the reload latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= RST_VAL;
        end else begin
            lat_q <= lat_next;
        end
    end

    // Purpose: count down, reload at zero and flag the underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
            uf_q  <= 1'b0;
        end else if (ld_cnt_i) begin
            cnt_q <= wdata_i;
            uf_q  <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == '0) begin
                cnt_q <= lat_next;
                uf_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
                uf_q  <= 1'b0;
            end
        end else begin
            uf_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign uf_o  = uf_q;

endmodule

// File: rtl/tt_toggle.sv
// Module: toggle output stage.
// While disabled the pin shows the programmed start level (start_low=1 -> low).
// A control write that turns the enable on loads the start level carried by that
// write; while enabled the pin inverts on each underflow pulse.
// Assumes ctrl_wr_i is high for exactly the cycle of a control write.
module tt_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic wr_en_i,
    input  logic wr_low_i,
    input  logic en_q_i,
    input  logic low_q_i,
    input  logic uf_i,
    output logic pin_o
);
    logic pin_q;

    // Purpose: select between start level, enable reload and inversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else if (ctrl_wr_i && wr_en_i && !en_q_i) begin
            pin_q <= ~wr_low_i;
        end else if (!en_q_i) begin
            pin_q <= ~low_q_i;
        end else if (uf_i) begin
            pin_q <= ~pin_q;
        end
    end

    assign pin_o = pin_q;

endmodule

// File: rtl/tri_timer_unit.sv
// Module: top of the three-stage cascadable timer.
// Decodes the register bus, holds the control register, routes count enables
// (prescaler, sub-clock tick, counter one underflow) and drives the toggle pin
// from counter two underflows. Assumes bus writes are single-cycle strobes and
// that subtick_i is already synchronous to clk.
module tri_timer_unit
    import tt_pkg::*;
#(
    parameter int unsigned TW = 8,
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lowspd_i,
    input  logic          subtick_i,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    output logic          tgl_o
);
    localparam int unsigned CW = $bits(ctrl_t);

    ctrl_t                     ctrl_q;
    logic                      ctrl_wr;
    logic                      presc_adv;
    logic                      presc_pulse;
    logic [N_TMR-1:0]          tick_v;
    logic [N_TMR-1:0]          uf_v;
    logic [N_TMR-1:0]          hit_v;
    logic [N_TMR-1:0][TW-1:0]  cnt_v;

    // Purpose: decode a write to the control register.
    always_comb begin
        ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
    end

    // Purpose: hold the implemented control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(bus_wdata[CW-1:0]);
        end
    end

    // Purpose: prescaler advances every cycle, or per sub-clock tick in low-speed mode.
    always_comb begin
        presc_adv = lowspd_i ? subtick_i : 1'b1;
    end

    tt_prescale #(.PW(PW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (presc_adv),
        .pulse_o (presc_pulse)
    );

    // Purpose: route the count enable of each counter.
    always_comb begin
        tick_v[0] = ctrl_q.t1_sub  ? subtick_i   : presc_pulse;
        tick_v[1] = ctrl_q.t2_fast ? presc_pulse : uf_v[0];
        tick_v[2] = ctrl_q.t3_fast ? presc_pulse : uf_v[0];
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_TMR; gi++) begin : g_tmr
            logic ld_cnt;

            // Purpose: address hit and load type for this counter.
            always_comb begin
                hit_v[gi] = bus_we && (bus_addr == AW'(gi));
                if (gi == 1) begin
                    ld_cnt = hit_v[gi] && !ctrl_q.t2_latonly;
                end else begin
                    ld_cnt = hit_v[gi];
                end
            end

            tt_counter #(.W(TW)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_i   (tick_v[gi]),
                .ld_lat_i (hit_v[gi]),
                .ld_cnt_i (ld_cnt),
                .wdata_i  (bus_wdata[TW-1:0]),
                .cnt_o    (cnt_v[gi]),
                .uf_o     (uf_v[gi])
            );
        end
    endgenerate

    tt_toggle u_tgl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (ctrl_wr),
        .wr_en_i   (bus_wdata[1]),
        .wr_low_i  (bus_wdata[0]),
        .en_q_i    (ctrl_q.tgl_en),
        .low_q_i   (ctrl_q.tgl_low),
        .uf_i      (uf_v[1]),
        .pin_o     (tgl_o)
    );

    // Purpose: read multiplexer; counters return their live count.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata = DW'(ctrl_q);
        end else if (bus_addr < AW'(N_TMR)) begin
            bus_rdata = DW'(cnt_v[bus_addr]);
        end
    end

endmodule

// File: rtl/tt_checker.sv
// Module: property checker bound to tri_timer_unit.
// Observes bus, pin, control register, count enables, underflows and counter two.
module tt_checker #(
    parameter int unsigned TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    bus_addr,
    input logic [7:0]    bus_rdata,
    input logic          bus_we,
    input logic          tgl_o,
    input logic [5:0]    ctrl,
    input logic [2:0]    tick_v,
    input logic [2:0]    uf_v,
    input logic [TW-1:0] cnt2
);
    logic wr2;
    logic ctrl_wr;

    always_comb begin
        wr2     = bus_we && (bus_addr == 2'd1);
        ctrl_wr = bus_we && (bus_addr == 2'd3);
    end

    always_comb begin
        if (rst_n && bus_addr == 2'd3) begin
            AST_CTRL_HIGH_ZERO: assert (bus_rdata[7:6] == 2'b00); // R1
        end
    end

    AST_UF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_v != 3'b000) |-> (($past(tick_v) & uf_v) == uf_v)); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_v[1] && !wr2 && cnt2 != '0) |=> (cnt2 == $past(cnt2) - 1'b1)); // R3

    AST_LATCH_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr2 && ctrl[2] && !tick_v[1]) |=> $stable(cnt2)); // R5

    AST_TGL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_o != $past(tgl_o)) |-> ($past(uf_v[1]) || $past(ctrl_wr) || !$past(ctrl[1]))); // R10

    AST_TGL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[1] && !ctrl_wr) |=> (tgl_o == ~$past(ctrl[0]))); // R9

endmodule

bind tri_timer_unit tt_checker #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_we    (bus_we),
    .tgl_o     (tgl_o),
    .ctrl      (ctrl_q),
    .tick_v    (tick_v),
    .uf_v      (uf_v),
    .cnt2      (cnt_v[1])
);

// File: tb/sim_tri_timer_unit.sv
module sim_tri_timer_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lowspd_i = 1'b0;
    logic       subtick_i = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       tgl_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tri_timer_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lowspd_i  (lowspd_i),
        .subtick_i (subtick_i),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .tgl_o     (tgl_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic sub_tick();
        @(negedge clk); subtick_i = 1'b1;
        @(negedge clk); subtick_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd3, d); check("R1 ctrl reset", d, 8'h00);
        rd(2'd0, d); check("R2 cnt1 reset", d, 8'hFF);
        rd(2'd2, d); check("R2 cnt3 reset", d, 8'hFF);
        check("R9 pin reset high", tgl_o, 1);
        wr(2'd3, 8'hC0);
        rd(2'd3, d); check("R1 high bits read 0", d, 8'h00);
        wr(2'd3, 8'hFC);
        rd(2'd3, d); check("R1 low bits kept", d, 8'h3C);
    endtask

    task automatic t_chain();
        logic [7:0] d;
        wr(2'd3, 8'h20);
        wr(2'd0, 8'd1); wr(2'd1, 8'd5); wr(2'd2, 8'd7);
        rd(2'd1, d); check("R4 cnt2 both-load", d, 5);
        sub_tick();
        rd(2'd0, d); check("R3 R6 cnt1 step", d, 0);
        sub_tick();
        rd(2'd0, d); check("R3 cnt1 reload", d, 1);
        repeat (2) sub_tick();
        rd(2'd1, d); check("R7 cnt2 chained", d, 3);
        rd(2'd2, d); check("R7 cnt3 chained", d, 5);
    endtask

    task automatic t_toggle();
        logic [7:0] d;
        wr(2'd0, 8'd0); wr(2'd1, 8'd0);
        wr(2'd3, 8'h23);
        check("R10 enable loads low start", tgl_o, 0);
        sub_tick(); check("R10 invert 1", tgl_o, 1);
        sub_tick(); check("R10 invert 2", tgl_o, 0);
        sub_tick(); check("R10 invert 3", tgl_o, 1);
        wr(2'd3, 8'h21); @(negedge clk);
        check("R9 disabled start low", tgl_o, 0);
        sub_tick(); check("R9 underflow ignored", tgl_o, 0);
        wr(2'd3, 8'h20); @(negedge clk);
        check("R9 disabled start high", tgl_o, 1);
        rd(2'd1, d); check("R3 cnt2 at zero", d, 0);
    endtask

    task automatic t_latch_only();
        logic [7:0] d;
        wr(2'd0, 8'd0); wr(2'd1, 8'd0);
        wr(2'd3, 8'h24);
        wr(2'd1, 8'd9);
        rd(2'd1, d); check("R5 count untouched", d, 0);
        sub_tick();
        rd(2'd1, d); check("R5 reload new latch", d, 9);
        sub_tick();
        rd(2'd1, d); check("R5 then counts", d, 8);
        // drive counter two back to zero with a both-load write
        wr(2'd3, 8'h20); wr(2'd1, 8'd0); wr(2'd3, 8'h24);
        // collision: latch-only write lands in the cycle counter two underflows
        @(negedge clk); subtick_i = 1'b1;
        @(negedge clk); subtick_i = 1'b0;
        bus_addr = 2'd1; bus_wdata = 8'h42; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(2'd1, d); check("R5 collision takes new value", d, 8'h42);
        sub_tick();
        rd(2'd1, d); check("R5 collision then counts", d, 8'h41);
    endtask

    task automatic t_prescale();
        logic [7:0] d;
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h50);
        repeat (16) @(posedge clk);
        rd(2'd0, d); check("R6 R8 one pulse per 16 clocks", d, 8'h4F);
        wr(2'd3, 8'h18);
        wr(2'd1, 8'h30);
        repeat (16) @(posedge clk);
        rd(2'd1, d); check("R7 cnt2 from prescaler", d, 8'h2F);
        wr(2'd2, 8'h30);
        repeat (32) @(posedge clk);
        rd(2'd2, d); check("R7 cnt3 from prescaler", d, 8'h2E);
        lowspd_i = 1'b1;
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h50);
        repeat (40) @(negedge clk);
        rd(2'd0, d); check("R8 low-speed no ticks", d, 8'h50);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); subtick_i = 1'b1;
            @(negedge clk); subtick_i = 1'b0;
        end
        rd(2'd0, d); check("R8 one pulse per 16 ticks", d, 8'h4F);
        lowspd_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chain();
        t_toggle();
        t_latch_only();
        t_prescale();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule